// File: doc/BRIEF.md
# Three-Channel Register-Mapped Watchdog

The block holds three watchdog channels behind one 32-bit register bus (word address, write strobe, write data, combinational read data). Each channel has a free-running 32-bit tick counter that software may overwrite at any time, a reset-threshold register and a control register. An enable pulse that is already synchronized to the bus clock advances every counter by one. Channel 0 also has a warning threshold with a sticky interrupt flag and a level interrupt output.

A channel asks for a reset while its reset-arm bit is set and its counter is at or above its reset threshold. Channel 0 drives a dedicated recovery-reset output. Channels 1 and 2 share the normal system-reset output. Software keeps a channel quiet by writing zero to its counter before the threshold is reached. To force an immediate restart, software arms the channel and then writes zero to the threshold and to the counter.

Top module: `tri_watchdog`

## Requirements
- R1: After reset every counter and control register reads 0, every threshold register reads 0xFFFFFFFF, and all three outputs are low.
- R2: A counter increases by one on each cycle where tick_i is high, and it wraps from 0xFFFFFFFF to 0. Counting does not depend on any control bit.
- R3: A bus write to a counter in the same cycle as a tick loads the written value, and the tick is lost.
- R4: Byte offsets: channel 0 counter 0x00, reset threshold 0x04, warning threshold 0x08, control 0x0C. Channel 1 uses 0x10, 0x14 and control 0x1C. Channel 2 uses 0x20, 0x24 and control 0x2C. Reads return the live register value in the same cycle.
- R5: Control bits: bit 0 interrupt enable, bit 1 interrupt flag, bit 2 reset arm. On channels 1 and 2, bits 0 and 1 always read 0.
- R6: recov_rst_o is high while channel 0 is armed and its counter is greater than or equal to its reset threshold. sys_rst_o is the same condition ORed over channels 1 and 2. Clearing the arm bit drops the request in the cycle after the write.
- R7: While the interrupt enable is set and the channel 0 counter is greater than or equal to the warning threshold, the interrupt flag is set on the next clock edge. irq_o follows the flag.
- R8: Writing 1 to control bit 1 clears the flag. Writing 0 leaves it unchanged. If the warning condition is still true, the flag stays set.
- R9: Any offset not listed in R4, including addresses with nonzero low two bits, reads as 0 and ignores writes.
- R10: Writing reset arm, then a threshold of 0, then a counter of 0 raises the reset output in the cycle right after the counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Synchronized reference tick enable |
| bus_addr_i | input | 6 | Byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| recov_rst_o | output | 1 | Recovery reset request from channel 0 |
| sys_rst_o | output | 1 | System reset request from channel 1 or 2 |
| irq_o | output | 1 | Channel 0 warning interrupt |

## Verification
The bench aims at the counter wrap at all ones: a design that saturates or carries wrongly would read a nonzero value after the wrap. It also covers a counter write in the same cycle as a tick: a design that gives the tick priority would read one more than the written value. It checks that a flag clear is overridden while the warning condition still holds, and that a written 0 leaves the flag alone. A design that clears the flag unconditionally would lose a live warning, and one that does not latch the flag would drop irq_o. It also runs the zero-threshold restart sequence and writes to holes in the map: a design using strict greater-than would never reset, and one with loose decoding would alias a hole onto a real register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned WD_DATA_W = 32;
    localparam int unsigned CTL_IEN   = 0;
    localparam int unsigned CTL_IST   = 1;
    localparam int unsigned CTL_REN   = 2;
    localparam int unsigned CTL_W     = 3;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_RCMP = 2'd1,
        REG_ICMP = 2'd2,
        REG_CTL  = 2'd3
    } wd_reg_e;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NCH    = 3,
    localparam int CH_W  = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic              hit_o,
    output logic [CH_W-1:0]   ch_o,
    output wd_reg_e           reg_o,
    output logic [NCH-1:0]    wr_cnt_o,
    output logic [NCH-1:0]    wr_rcmp_o,
    output logic [NCH-1:0]    wr_icmp_o,
    output logic [NCH-1:0]    wr_ctl_o
);
    always_comb begin
        ch_o  = addr_i[ADDR_W-1:4];
        reg_o = wd_reg_e'(addr_i[3:2]);
        hit_o = (addr_i[1:0] == 2'b00) && (int'(ch_o) < NCH)
                && ((reg_o != REG_ICMP) || (ch_o == '0));
        for (int i = 0; i < NCH; i++) begin
            wr_cnt_o[i]  = we_i && hit_o && (ch_o == CH_W'(i)) && (reg_o == REG_CNT);
            wr_rcmp_o[i] = we_i && hit_o && (ch_o == CH_W'(i)) && (reg_o == REG_RCMP);
            wr_icmp_o[i] = we_i && hit_o && (ch_o == CH_W'(i)) && (reg_o == REG_ICMP);
            wr_ctl_o[i]  = we_i && hit_o && (ch_o == CH_W'(i)) && (reg_o == REG_CTL);
        end
    end
endmodule

// File: rtl/wdog_chan.sv
module wdog_chan
    import wdog_pkg::*;
#(
    parameter int DATA_W  = WD_DATA_W,
    parameter bit HAS_IRQ = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_cnt_i,
    input  logic              wr_rcmp_i,
    input  logic              wr_icmp_i,
    input  logic              wr_ctl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] rcmp_o,
    output logic [DATA_W-1:0] icmp_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              rst_req_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] rcmp;
        logic [DATA_W-1:0] icmp;
        logic              ien;
        logic              ist;
        logic              ren;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     warn_hit;

    always_comb begin
        st_d     = st_q;
        warn_hit = st_q.ien && (st_q.cnt >= st_q.icmp);
        if (wr_cnt_i)      st_d.cnt = wdata_i;
        else if (tick_i)   st_d.cnt = st_q.cnt + DATA_W'(1);
        if (wr_rcmp_i)     st_d.rcmp = wdata_i;
        if (wr_ctl_i)      st_d.ren = wdata_i[CTL_REN];
        if (HAS_IRQ) begin
            if (wr_icmp_i) st_d.icmp = wdata_i;
            if (wr_ctl_i)  st_d.ien = wdata_i[CTL_IEN];
            st_d.ist = warn_hit || (st_q.ist && !(wr_ctl_i && wdata_i[CTL_IST]));
        end else begin
            st_d.icmp = '1;
            st_d.ien  = 1'b0;
            st_d.ist  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, rcmp: '1, icmp: '1, ien: 1'b0, ist: 1'b0, ren: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign rcmp_o    = st_q.rcmp;
    assign icmp_o    = st_q.icmp;
    assign ctl_o     = {st_q.ren, st_q.ist, st_q.ien};
    assign rst_req_o = st_q.ren && (st_q.cnt >= st_q.rcmp);
    assign irq_o     = st_q.ist;

    // R3
    cnt_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (cnt_o == $past(wdata_i)));

    // R2
    cnt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cnt_i) |=> (cnt_o == $past(cnt_o) + DATA_W'(1)));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[CTL_IEN] && (cnt_o >= icmp_o)) |=> irq_o);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_ctl_i && wdata_i[CTL_IST])) |=> irq_o);

    // R6
    rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl_i && !wdata_i[CTL_REN]) |=> !rst_req_o);
endmodule

// File: rtl/tri_watchdog.sv
module tri_watchdog
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = WD_DATA_W,
    parameter int NCH    = 3,
    localparam int CH_W  = ADDR_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              recov_rst_o,
    output logic              sys_rst_o,
    output logic              irq_o
);
    logic              hit;
    logic [CH_W-1:0]   ch_sel;
    wd_reg_e           reg_sel;
    logic [NCH-1:0]    wr_cnt, wr_rcmp, wr_icmp, wr_ctl;
    logic [DATA_W-1:0] cnt_w  [NCH];
    logic [DATA_W-1:0] rcmp_w [NCH];
    logic [DATA_W-1:0] icmp_w [NCH];
    logic [CTL_W-1:0]  ctl_w  [NCH];
    logic [NCH-1:0]    rst_req, irq_vec;

    wdog_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) i_decode (
        .addr_i    (bus_addr_i),
        .we_i      (bus_we_i),
        .hit_o     (hit),
        .ch_o      (ch_sel),
        .reg_o     (reg_sel),
        .wr_cnt_o  (wr_cnt),
        .wr_rcmp_o (wr_rcmp),
        .wr_icmp_o (wr_icmp),
        .wr_ctl_o  (wr_ctl)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        wdog_chan #(.DATA_W(DATA_W), .HAS_IRQ(g == 0)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .wr_cnt_i  (wr_cnt[g]),
            .wr_rcmp_i (wr_rcmp[g]),
            .wr_icmp_i (wr_icmp[g]),
            .wr_ctl_i  (wr_ctl[g]),
            .wdata_i   (bus_wdata_i),
            .cnt_o     (cnt_w[g]),
            .rcmp_o    (rcmp_w[g]),
            .icmp_o    (icmp_w[g]),
            .ctl_o     (ctl_w[g]),
            .rst_req_o (rst_req[g]),
            .irq_o     (irq_vec[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit) begin
            unique case (reg_sel)
                REG_CNT:  bus_rdata_o = cnt_w[ch_sel];
                REG_RCMP: bus_rdata_o = rcmp_w[ch_sel];
                REG_ICMP: bus_rdata_o = icmp_w[ch_sel];
                REG_CTL:  bus_rdata_o = DATA_W'(ctl_w[ch_sel]);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign recov_rst_o = rst_req[0];
    assign sys_rst_o   = |rst_req[NCH-1:1];
    assign irq_o       = |irq_vec;

    // R9
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i[1:0] != 2'b00) |-> (bus_rdata_o == '0));
endmodule

// File: tb/test_tri_watchdog.sv
module test_tri_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        recov, sysr, irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt [3];
    logic [31:0] m_rcmp [3];
    logic [31:0] m_icmp;
    logic        m_ien, m_ist;
    logic        m_ren [3];

    logic [31:0] s_rdata;
    logic        s_recov, s_sys, s_irq;

    always #10 clk = ~clk;

    tri_watchdog i_tri_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .recov_rst_o(recov), .sys_rst_o(sysr), .irq_o(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [5:0] a);
        int ch = int'(a[5:4]);
        if (a[1:0] != 2'b00 || ch == 3) return 32'h0;
        case (a[3:2])
            2'd0: return m_cnt[ch];
            2'd1: return m_rcmp[ch];
            2'd2: return (ch == 0) ? m_icmp : 32'h0;
            default: return (ch == 0) ? {29'h0, m_ren[0], m_ist, m_ien}
                                      : {29'h0, m_ren[ch], 2'b00};
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 32'h0; m_rcmp[c] = 32'hFFFF_FFFF; m_ren[c] = 1'b0;
        end
        m_icmp = 32'hFFFF_FFFF; m_ien = 1'b0; m_ist = 1'b0;
    endtask

    task automatic model_update(logic w, logic [5:0] a, logic [31:0] d, logic tk);
        logic set_f = m_ien && (m_cnt[0] >= m_icmp);
        logic ok = w && (a[1:0] == 2'b00);
        for (int c = 0; c < 3; c++) begin
            logic sel = ok && (int'(a[5:4]) == c);
            if (sel && a[3:2] == 2'd0) m_cnt[c] = d;
            else if (tk)               m_cnt[c] = m_cnt[c] + 32'd1;
            if (sel && a[3:2] == 2'd1) m_rcmp[c] = d;
            if (sel && a[3:2] == 2'd3) m_ren[c] = d[2];
        end
        if (ok && a[5:4] == 2'd0 && a[3:2] == 2'd2) m_icmp = d;
        if (ok && a[5:4] == 2'd0 && a[3:2] == 2'd3) begin
            m_ien = d[0];
            m_ist = set_f || (m_ist && !d[1]);
        end else begin
            m_ist = set_f || m_ist;
        end
    endtask

    task automatic step(logic w, logic [5:0] a, logic [31:0] d, logic tk);
        @(negedge clk);
        we = w; addr = a; wdata = d; tick = tk;
        #1;
        s_rdata = rdata; s_recov = recov; s_sys = sysr; s_irq = irq;
        check("R4 read", s_rdata, exp_read(a));
        check("R6 recovery reset", {31'h0, s_recov},
              {31'h0, m_ren[0] && (m_cnt[0] >= m_rcmp[0])});
        check("R6 system reset", {31'h0, s_sys},
              {31'h0, (m_ren[1] && m_cnt[1] >= m_rcmp[1]) || (m_ren[2] && m_cnt[2] >= m_rcmp[2])});
        check("R7 irq", {31'h0, s_irq}, {31'h0, m_ist});
        @(posedge clk);
        model_update(w, a, d, tk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 12; k++) begin
            logic [5:0] a = 6'(k * 4);
            step(1'b0, a, 32'h0, 1'b0);
            if (a[3:2] == 2'd1) check("R1 threshold reset", s_rdata, 32'hFFFF_FFFF);
            if (a[3:2] == 2'd3 || a[3:2] == 2'd0) check("R1 zero reset", s_rdata, 32'h0);
            check("R1 outputs low", {29'h0, s_recov, s_sys, s_irq}, 32'h0);
        end

        // R2 wrap
        step(1'b1, 6'h00, 32'hFFFF_FFFF, 1'b0);
        step(1'b0, 6'h00, 32'h0, 1'b1);
        check("R2 before wrap", s_rdata, 32'hFFFF_FFFF);
        step(1'b0, 6'h00, 32'h0, 1'b0);
        check("R2 after wrap", s_rdata, 32'h0);

        // R3 write beats tick
        step(1'b1, 6'h10, 32'd5, 1'b1);
        step(1'b0, 6'h10, 32'h0, 1'b0);
        check("R3 write priority", s_rdata, 32'd5);

        // R9 holes
        step(1'b1, 6'h18, 32'h1234, 1'b0);
        step(1'b1, 6'h15, 32'h0, 1'b0);
        step(1'b0, 6'h18, 32'h0, 1'b0);
        check("R9 hole reads zero", s_rdata, 32'h0);
        step(1'b0, 6'h14, 32'h0, 1'b0);
        check("R9 neighbour untouched", s_rdata, 32'hFFFF_FFFF);

        // R5 control bits on channel 1
        step(1'b1, 6'h1C, 32'h7, 1'b0);
        step(1'b0, 6'h1C, 32'h0, 1'b0);
        check("R5 ch1 control", s_rdata, 32'h4);
        step(1'b1, 6'h1C, 32'h0, 1'b0);

        // R7 / R8 warning on channel 0
        step(1'b1, 6'h08, 32'd3, 1'b0);
        step(1'b1, 6'h00, 32'd0, 1'b0);
        step(1'b1, 6'h0C, 32'h1, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 6'h0C, 32'h0, 1'b1);
        step(1'b0, 6'h0C, 32'h0, 1'b0);
        check("R7 flag not yet", {31'h0, s_irq}, 32'h0);
        step(1'b0, 6'h0C, 32'h0, 1'b0);
        check("R7 flag set", {31'h0, s_irq}, 32'h1);
        check("R5 ch0 control", s_rdata, 32'h3);
        step(1'b1, 6'h0C, 32'h3, 1'b0);
        step(1'b0, 6'h0C, 32'h0, 1'b0);
        check("R8 clear overridden", {31'h0, s_irq}, 32'h1);
        step(1'b1, 6'h00, 32'd0, 1'b0);
        step(1'b1, 6'h0C, 32'h1, 1'b0);
        step(1'b0, 6'h0C, 32'h0, 1'b0);
        check("R8 write zero keeps flag", {31'h0, s_irq}, 32'h1);
        step(1'b1, 6'h0C, 32'h3, 1'b0);
        step(1'b0, 6'h0C, 32'h0, 1'b0);
        check("R8 flag cleared", {31'h0, s_irq}, 32'h0);
        step(1'b1, 6'h0C, 32'h0, 1'b0);

        // R6 recovery reset and its drop
        step(1'b1, 6'h04, 32'd2, 1'b0);
        step(1'b1, 6'h00, 32'd2, 1'b0);
        step(1'b1, 6'h0C, 32'h4, 1'b0);
        step(1'b0, 6'h00, 32'h0, 1'b0);
        check("R6 recovery high", {31'h0, s_recov}, 32'h1);
        check("R6 system low", {31'h0, s_sys}, 32'h0);
        step(1'b1, 6'h0C, 32'h0, 1'b0);
        step(1'b0, 6'h00, 32'h0, 1'b0);
        check("R6 recovery dropped", {31'h0, s_recov}, 32'h0);

        // R10 immediate restart on channel 2
        step(1'b1, 6'h2C, 32'h4, 1'b0);
        step(1'b1, 6'h24, 32'h0, 1'b0);
        step(1'b1, 6'h20, 32'h0, 1'b0);
        step(1'b0, 6'h20, 32'h0, 1'b0);
        check("R10 immediate reset", {31'h0, s_sys}, 32'h1);
        step(1'b1, 6'h2C, 32'h0, 1'b0);
        step(1'b0, 6'h20, 32'h0, 1'b0);
        check("R6 system dropped", {31'h0, s_sys}, 32'h0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [5:0]  a = ($urandom % 8 == 0) ? 6'($urandom) : 6'(($urandom % 16) * 4);
            logic        w = ($urandom % 4 == 0);
            logic [31:0] d = ($urandom % 2 == 0) ? 32'($urandom % 64) : $urandom;
            step(w, a, d, 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule